// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block collects single-cycle event pulses from the transmit and receive engines of a network controller. Each pulse sets a sticky bit in a 32-bit event word. The event bits sit in fixed high-order positions. Software reads that word and clears bits by writing ones to them. A second 32-bit word holds a mask, and software replaces it with a plain write. Each of 13 discrete interrupt lines is driven by a register that follows the AND of one event bit and the matching mask bit, one clock later.

The register port is a simple single-cycle interface: a write strobe, a one-bit word select, write data, and read data that always shows the selected word. Nothing in this block carries streaming data, so there is no handshake and no back-pressure. Every write completes in the cycle its strobe is sampled. Priority between lines and routing to a processor belong to logic outside this block.

Top module: `evt_irq_fanout`

## Requirements
- R1: While reset is held and on the first cycle after it, the event word, the mask word and all 13 lines are zero.
- R2: A pulse on `evt_pulse[i]` at a clock edge makes the event bit for line i readable as 1 from that edge on. The bit positions by line index 0..12 are 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R3: A write with `reg_addr`=0 clears every event bit that is 1 in `reg_wdata` and leaves the bits written as 0 unchanged.
- R4: When a pulse and a clearing write hit the same event bit at the same edge, the bit ends up set.
- R5: A write with `reg_addr`=1 replaces the whole implemented mask with `reg_wdata`. Without such a write the mask holds.
- R6: `irq_line[i]` equals the AND of line i's event bit and mask bit as they stood one cycle earlier.
- R7: The line order 0..12 is: transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, management done, late collision, heartbeat, graceful stop done, bus error, babbling transmit, babbling receive. Each line uses the bit position that R2 gives for its index.
- R8: Bits 18..0 of both words read as zero, and writes to those bits have no effect.
- R9: An event bit stays set through any number of cycles without a clearing write, including writes to the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 13 | Event set pulses, indexed in line order |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 event word, 1 mask word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_line | output | 13 | Registered interrupt lines |

## Verification
The assertions assume that every input is driven to a known value from the moment reset is released. `reg_addr` must also be a clean 0 or 1 whenever `reg_wr` is high. The bench drives all inputs to zero during reset and changes them only on the falling clock edge. Pulses, write data and the word select come from a controlled random source or from fixed patterns, so they are never undefined. The directed phases aim pulses and clearing writes at the same bits in the same cycle, and they write ones into the unimplemented low bits. The random phase mixes pulses, clears and mask writes freely.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_LINES = 13;
  localparam logic [REG_W-1:0] IMPL_MASK = 32'hFFF8_0000;

  // Bit position in the register word of each line, by line index.
  function automatic int line_bit(input int line);
    case (line)
      0:  return 27;
      1:  return 26;
      2:  return 19;
      3:  return 20;
      4:  return 25;
      5:  return 24;
      6:  return 23;
      7:  return 21;
      8:  return 31;
      9:  return 28;
      10: return 22;
      11: return 29;
      12: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] spread(input logic [NUM_LINES-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LINES; i++) r[line_bit(i)] = v[i];
    return r;
  endfunction

  function automatic logic [NUM_LINES-1:0] gather(input logic [REG_W-1:0] w);
    logic [NUM_LINES-1:0] r;
    for (int i = 0; i < NUM_LINES; i++) r[i] = w[line_bit(i)];
    return r;
  endfunction
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] ev_q;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_en_i ? clr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~clr_eff) | set_i;
  end

  assign ev_o = ev_q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & $past(set_i)) == $past(set_i));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & $past(clr_eff & ~set_i)) == '0);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q ^ $past(ev_q)) & ~$past(set_i | clr_eff)) == '0);
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_i) |-> mask_q == $past(wdata_i));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> $stable(mask_q));
endmodule

// File: rtl/line_drive.sv
module line_drive #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] line_o
);
  logic [N-1:0] line_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[g] <= 1'b0;
      else        line_q[g] <= ev_i[g] & mask_i[g];
    end
  end

  assign line_o = line_q;

  // R6
  line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q == $past(ev_i & mask_i));
endmodule

// File: rtl/evt_irq_fanout.sv
module evt_irq_fanout
  import evt_irq_pkg::*;
#(
  parameter int REG_WIDTH = evt_irq_pkg::REG_W,
  parameter int LINES     = evt_irq_pkg::NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES-1:0]     evt_pulse,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [REG_WIDTH-1:0] reg_wdata,
  output logic [REG_WIDTH-1:0] reg_rdata,
  output logic [LINES-1:0]     irq_line
);
  logic [LINES-1:0] ev_bits;
  logic [LINES-1:0] mask_bits;
  logic [LINES-1:0] wr_lines;
  logic             ev_wr;
  logic             mask_wr;

  assign ev_wr    = reg_wr && (reg_addr == 1'b0);
  assign mask_wr  = reg_wr && (reg_addr == 1'b1);
  assign wr_lines = gather(reg_wdata);

  evt_latch #(.N(LINES)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_pulse),
    .clr_en_i (ev_wr),
    .clr_i    (wr_lines),
    .ev_o     (ev_bits)
  );

  mask_reg #(.N(LINES)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (wr_lines),
    .mask_o  (mask_bits)
  );

  line_drive #(.N(LINES)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_bits),
    .mask_i (mask_bits),
    .line_o (irq_line)
  );

  assign reg_rdata = reg_addr ? spread(mask_bits) : spread(ev_bits);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_line == '0));
endmodule

// File: tb/evt_irq_fanout_tb.sv
`timescale 1ns/1ps
module evt_irq_fanout_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] evt_pulse = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] irq_line;

  always #2.5 clk = ~clk;

  evt_irq_fanout dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int pos [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
  logic [31:0] ev_m = '0;
  logic [31:0] mk_m = '0;
  logic [12:0] ln_m = '0;

  function automatic logic [31:0] to_word(input logic [12:0] p);
    logic [31:0] w = '0;
    for (int i = 0; i < 13; i++) if (p[i]) w[pos[i]] = 1'b1;
    return w;
  endfunction

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    exp_rd = reg_addr ? mk_m : ev_m;
    n_cmp++;
    if (reg_rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, exp_rd);
    end
    n_cmp++;
    if (irq_line !== ln_m) begin
      n_bad++;
      $display("FAIL %s lines actual=%b expected=%b", tag, irq_line, ln_m);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, advance model, compare.
  task automatic step(input logic [12:0] p, input logic wr, input logic a,
                      input logic [31:0] d, input string tag);
    evt_pulse = p; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 13; i++) ln_m[i] = ev_m[pos[i]] & mk_m[pos[i]];
    if (wr && !a) ev_m = ev_m & ~d;
    ev_m = (ev_m | to_word(p)) & 32'hFFF8_0000;
    if (wr && a) mk_m = d & 32'hFFF8_0000;
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reg_addr = 1'b0; #0.1; compare("R1 reset event");
    reg_addr = 1'b1; #0.1; compare("R1 reset mask");
    rst_n = 1'b1;
    step('0, 0, 0, '0, "R1 after reset");
    // R2 R7: each line alone
    for (int i = 0; i < 13; i++) begin
      step(13'(1) << i, 0, 0, '0, "R2 single pulse");
      step('0, 0, 0, '0, "R7 readback");
    end
    // R5 R8: full mask write, low bits dropped
    step('0, 1, 1, 32'hFFFF_FFFF, "R5 mask all");
    step('0, 0, 1, '0, "R8 mask low bits");
    step('0, 0, 0, '0, "R6 lines up");
    // R3: partial clear
    step('0, 1, 0, 32'h0A0A_0000, "R3 partial clear");
    repeat (4) step('0, 0, 0, '0, "R9 sticky");
    step('0, 1, 1, 32'h5555_0000, "R9 mask write keeps events");
    step('0, 0, 0, '0, "R6 masked lines");
    // R4: set and clear same bit same cycle
    step(13'h1FFF, 1, 0, 32'hFFFF_FFFF, "R4 set beats clear");
    step('0, 0, 0, '0, "R4 still set");
    // R8: writes to low bits ignored
    step('0, 1, 0, 32'h0007_FFFF, "R8 low clear ignored");
    step('0, 1, 1, 32'h0007_FFFF, "R8 low mask write");
    step('0, 1, 0, 32'hFFFF_FFFF, "R3 clear all");
    step('0, 0, 0, '0, "R6 lines drop");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [12:0] p;
      logic wr;
      logic a;
      logic [31:0] d;
      p  = 13'($urandom) & 13'($urandom);
      wr = ($urandom % 3) == 0;
      a  = 1'($urandom);
      d  = $urandom;
      step(p, wr, a, d, "R6 random");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule